// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block is the integer execute stage of a small scalar core. It takes a raw 32-bit instruction word and two source operands of the data width. It decodes the register-register and register-immediate arithmetic and logic classes. It returns the destination value and a flag for encodings it does not accept. The instruction fields for destination and source register numbers are not looked at: the register file sits outside and delivers the operands.

The decode and the datapath are separate modules. They are joined by a struct of one-hot operation strobes. An optional output register adds one cycle of latency. The data width can be 32, 64 or 128. The shift-amount width is log2 of the data width, for both register shifts and immediate shifts.

Top module: `int_alu_top`

## Requirements
- R1: Opcode 0110011 (instruction bits [6:0]) selects the register form and opcode 0010011 selects the immediate form. Any other opcode sets `illegal`.
- R2: funct3 (bits [14:12]) selects the operation: 000 add/sub, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 right shift, 110 or, 111 and.
- R3: In the register form, funct7 (bits [31:25]) may be 0000000 or 0100000, and 0100000 is accepted only with funct3 000 (subtract) or 101 (arithmetic right shift). Every other funct7 value sets `illegal`.
- R4: A register shift uses only the low log2(W) bits of `srcB` as the distance. The higher bits of `srcB` have no effect.
- R5: An immediate shift takes its distance from instruction bits [20 +: log2(W)]. For right shifts, bit 30 picks arithmetic (1) or logical (0). The remaining upper bits of the 12-bit immediate must be zero, otherwise `illegal` is set.
- R6: For immediate forms other than shifts, the 12-bit immediate (bits [31:20]) is sign-extended to W bits. With funct3 000 this gives an add, with bit 30 taken as plain immediate data.
- R7: The signed and unsigned less-than results are 1 or 0, zero-extended to W bits. The immediate variants compare against the sign-extended immediate.
- R8: When `illegal` is 1, `result` is 0.
- R9: With the output register enabled (the default), `result` and `illegal` follow the inputs by one clock. Reset drives both to 0.
- R10: The following results hold: 0x76543210 arithmetic right shift by register 8 gives 0x00765432; 0x87654321 arithmetic right shift by immediate 4 gives 0xF8765432; a logical right shift by immediate 4 gives 0x08765432; 0x12345678 left shift by immediate 4 gives 0x23456780.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| srcA | input | W | First source operand |
| srcB | input | W | Second source operand (register form only) |
| result | output | W | Destination value |
| illegal | output | 1 | Encoding not accepted |

## Verification
The assertions assume that the instruction and the operands are stable and known across each clock edge in which they are captured. They also assume that reset is held for at least one edge before any check matters. The bench changes its inputs only on the falling edge and keeps them steady through the following rising edge. Outside reset it drives a new instruction every cycle. The random part of the stimulus draws across both opcode classes and all funct3 values. The directed part reaches the illegal encodings, shift distances with the high operand bits set, and the sign-extension edges.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  typedef struct packed {
    logic        doAdd;
    logic        doSub;
    logic        doAnd;
    logic        doOr;
    logic        doXor;
    logic        doSlt;
    logic        doSltu;
    logic        doSll;
    logic        doSrl;
    logic        doSra;
    logic        useImm;
    logic [11:0] imm;
  } aluCtl_t;
endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [31:0] instr,
  output aluCtl_t     ctl,
  output logic        illegal
);
  localparam int SHW = $clog2(W);
  localparam logic [31:0] HI_MASK = ~((32'd1 << (20 + SHW)) - 32'd1);
  localparam logic [31:0] BIT30   = 32'd1 << 30;

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       alt;
  logic       isReg;
  logic       isImm;
  logic       legal;
  logic       unusedFields;

  assign opc   = instr[6:0];
  assign f3    = instr[14:12];
  assign f7    = instr[31:25];
  assign alt   = instr[30];
  assign isReg = (opc == OPC_REG);
  assign isImm = (opc == OPC_IMM);
  assign unusedFields = ^{instr[19:15], instr[11:7]};

  always_comb begin
    legal = 1'b0;
    if (isReg) begin
      legal = (f7 == 7'b0000000) ||
              (f7 == 7'b0100000 && (f3 == 3'b000 || f3 == 3'b101));
    end else if (isImm) begin
      unique case (f3)
        3'b001:  legal = ((instr & HI_MASK) == 32'd0);
        3'b101:  legal = ((instr & HI_MASK & ~BIT30) == 32'd0);
        default: legal = 1'b1;
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.useImm = isImm;
    ctl.imm    = instr[31:20];
    if (legal) begin
      unique case (f3)
        3'b000: begin
          ctl.doSub = isReg & alt;
          ctl.doAdd = ~(isReg & alt);
        end
        3'b001: ctl.doSll  = 1'b1;
        3'b010: ctl.doSlt  = 1'b1;
        3'b011: ctl.doSltu = 1'b1;
        3'b100: ctl.doXor  = 1'b1;
        3'b101: begin
          ctl.doSra = alt;
          ctl.doSrl = ~alt;
        end
        3'b110: ctl.doOr   = 1'b1;
        3'b111: ctl.doAnd  = 1'b1;
        default: ;
      endcase
    end
  end

  assign illegal = ~legal;

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!(illegal && (ctl.doAdd | ctl.doSub | ctl.doAnd | ctl.doOr |
      ctl.doXor | ctl.doSlt | ctl.doSltu | ctl.doSll | ctl.doSrl | ctl.doSra))); // R8
  end
endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  aluCtl_t        ctl,
  input  logic [W-1:0]   srcA,
  input  logic [W-1:0]   srcB,
  output logic [W-1:0]   res
);
  localparam int SHW = $clog2(W);

  logic [W-1:0]   opB;
  logic [SHW-1:0] sh;
  logic [W-1:0]   sum;
  logic [W-1:0]   diff;
  logic           ltS;
  logic           ltU;

  assign opB  = ctl.useImm ? {{(W-12){ctl.imm[11]}}, ctl.imm} : srcB;
  assign sh   = opB[SHW-1:0];
  assign sum  = srcA + opB;
  assign diff = srcA - opB;
  assign ltS  = $signed(srcA) < $signed(opB);
  assign ltU  = srcA < opB;

  always_comb begin
    res = '0;
    res |= {W{ctl.doAdd}}  & sum;
    res |= {W{ctl.doSub}}  & diff;
    res |= {W{ctl.doAnd}}  & (srcA & opB);
    res |= {W{ctl.doOr}}   & (srcA | opB);
    res |= {W{ctl.doXor}}  & (srcA ^ opB);
    res |= {W{ctl.doSlt}}  & {{(W-1){1'b0}}, ltS};
    res |= {W{ctl.doSltu}} & {{(W-1){1'b0}}, ltU};
    res |= {W{ctl.doSll}}  & (srcA << sh);
    res |= {W{ctl.doSrl}}  & (srcA >> sh);
    res |= {W{ctl.doSra}}  & W'($signed(srcA) >>> sh);
  end

  always_comb begin
    AST_SLT_RANGE: assert (!(ctl.doSlt || ctl.doSltu) || res[W-1:1] == '0); // R7
    AST_SHIFT_ZERO: assert (!((ctl.doSll || ctl.doSrl || ctl.doSra) && sh == '0) || res == srcA); // R4
  end
endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
  import int_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  instr,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  output logic [W-1:0] result,
  output logic         illegal
);
  aluCtl_t      ctl;
  logic         illComb;
  logic [W-1:0] resComb;

  int_alu_ctrl #(.W(W)) u_ctrl (
    .instr   (instr),
    .ctl     (ctl),
    .illegal (illComb)
  );

  int_alu_dp #(.W(W)) u_dp (
    .ctl  (ctl),
    .srcA (srcA),
    .srcB (srcB),
    .res  (resComb)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result  <= '0;
          illegal <= 1'b0;
        end else begin
          result  <= resComb;
          illegal <= illComb;
        end
      end
    end else begin : g_comb
      assign result  = resComb;
      assign illegal = illComb;
    end
  endgenerate

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0)); // R8
  AST_ONEHOT_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doAdd, ctl.doSub, ctl.doAnd, ctl.doOr, ctl.doXor,
              ctl.doSlt, ctl.doSltu, ctl.doSll, ctl.doSrl, ctl.doSra})); // R2
endmodule

// File: tb/int_alu_top_bench.sv
`timescale 1ns/1ps
module int_alu_top_bench;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         ill;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  instr = '0;
  logic [W-1:0] srcA = '0;
  logic [W-1:0] srcB = '0;
  logic [W-1:0] result;
  logic         illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expItem_t pending[$];

  always #2.5 clk = ~clk;

  int_alu_top u_int_alu_top (
    .clk(clk), .rstN(rstN), .instr(instr),
    .srcA(srcA), .srcB(srcB), .result(result), .illegal(illegal)
  );

  function automatic logic [31:0] encR(input logic [6:0] f7, input logic [2:0] f3);
    return {f7, 5'd9, 5'd7, f3, 5'd3, 7'b0110011};
  endfunction

  function automatic logic [31:0] encI(input logic [11:0] imm, input logic [2:0] f3);
    return {imm, 5'd7, f3, 5'd3, 7'b0010011};
  endfunction

  task automatic refModel(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic ill);
    logic [31:0] bb;
    logic [2:0]  f3;
    logic [6:0]  f7;
    f3 = ins[14:12];
    f7 = ins[31:25];
    r = 32'd0;
    ill = 1'b0;
    if (ins[6:0] == 7'b0110011) begin
      bb = b;
      if (!(f7 == 7'd0 || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)))) ill = 1'b1;
    end else if (ins[6:0] == 7'b0010011) begin
      bb = {{20{ins[31]}}, ins[31:20]};
      if (f3 == 3'd1 && ins[31:25] != 7'd0) ill = 1'b1;
      if (f3 == 3'd5 && {ins[31], ins[29:25]} != 6'd0) ill = 1'b1;
    end else begin
      bb = 32'd0;
      ill = 1'b1;
    end
    if (!ill) begin
      case (f3)
        3'd0: r = (ins[6:0] == 7'b0110011 && ins[30]) ? a - bb : a + bb;
        3'd1: r = a << bb[4:0];
        3'd2: r = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
        3'd3: r = (a < bb) ? 32'd1 : 32'd0;
        3'd4: r = a ^ bb;
        3'd5: r = ins[30] ? 32'($signed(a) >>> bb[4:0]) : a >> bb[4:0];
        3'd6: r = a | bb;
        default: r = a & bb;
      endcase
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic expIll, input string tag);
    expItem_t it;
    @(negedge clk);
    instr = ins;
    srcA = a;
    srcB = b;
    it.res = expRes;
    it.ill = expIll;
    it.tag = tag;
    pending.push_back(it);
  endtask

  task automatic driveRef(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                          input string tag);
    logic [31:0] r;
    logic ill;
    refModel(ins, a, b, r, ill);
    drive(ins, a, b, r, ill, tag);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (pending.size() > 0) begin
        it = pending.pop_front();
        checks++;
        if (result !== it.res || illegal !== it.ill) begin
          fails++;
          $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                   it.tag, result, illegal, it.res, it.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stimulus
    // R9: reset state with live inputs applied
    instr = encR(7'd0, 3'd0);
    srcA = 32'd1;
    srcB = 32'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== '0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: result=%h illegal=%b expected result=0 illegal=0", result, illegal);
    end
    rstN = 1'b1;

    // R10 known values
    drive(encR(7'h20, 3'd5), 32'h76543210, 32'd8, 32'h00765432, 1'b0, "R10 sra reg");
    drive(encI(12'h404, 3'd5), 32'h87654321, 32'd0, 32'hF8765432, 1'b0, "R10 srai");
    drive(encI(12'h004, 3'd5), 32'h87654321, 32'd0, 32'h08765432, 1'b0, "R10 srli");
    drive(encI(12'h004, 3'd1), 32'h12345678, 32'd0, 32'h23456780, 1'b0, "R10 slli");
    // R3 subtract and funct7 legality
    drive(encR(7'h20, 3'd0), 32'd10, 32'd3, 32'd7, 1'b0, "R3 sub");
    drive(encR(7'h00, 3'd0), 32'd10, 32'd3, 32'd13, 1'b0, "R3 add");
    drive(encR(7'h20, 3'd1), 32'd10, 32'd3, 32'd0, 1'b1, "R3 alt sll illegal");
    drive(encR(7'h01, 3'd0), 32'd10, 32'd3, 32'd0, 1'b1, "R3 funct7 01 illegal");
    drive(encR(7'h20, 3'd7), 32'hF, 32'h3, 32'd0, 1'b1, "R3 alt and illegal");
    // R4 high bits of srcB ignored
    drive(encR(7'd0, 3'd1), 32'h1, 32'hFFFF_FFE3, 32'h8, 1'b0, "R4 sll high bits");
    drive(encR(7'd0, 3'd5), 32'h8000_0000, 32'h0000_0120, 32'h8000_0000, 1'b0, "R4 srl zero dist");
    // R5 immediate shift legality and distance
    drive(encI(12'h41F, 3'd5), 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 1'b0, "R5 srai 31");
    drive(encI(12'h024, 3'd1), 32'h1, 32'd0, 32'd0, 1'b1, "R5 slli upper bit illegal");
    drive(encI(12'h404, 3'd1), 32'h1, 32'd0, 32'd0, 1'b1, "R5 slli bit30 illegal");
    drive(encI(12'h804, 3'd5), 32'h1, 32'd0, 32'd0, 1'b1, "R5 srli bit31 illegal");
    // R6 sign extension, bit 30 as data
    drive(encI(12'h400, 3'd0), 32'd5, 32'hDEAD, 32'd1029, 1'b0, "R6 addi bit30 data");
    drive(encI(12'hFFF, 3'd0), 32'd5, 32'd0, 32'd4, 1'b0, "R6 addi minus one");
    drive(encI(12'h800, 3'd6), 32'd0, 32'd0, 32'hFFFF_F800, 1'b0, "R6 ori sign ext");
    // R7 comparisons
    drive(encR(7'd0, 3'd2), 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b0, "R7 slt signed");
    drive(encR(7'd0, 3'd3), 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, "R7 sltu unsigned");
    drive(encI(12'hFFF, 3'd3), 32'd5, 32'd0, 32'd1, 1'b0, "R7 sltiu ext");
    drive(encI(12'hFFF, 3'd2), 32'd5, 32'd0, 32'd0, 1'b0, "R7 slti ext");
    // R1 opcode decode, R8 zero on illegal
    drive({20'h12345, 5'd3, 7'b0000011}, 32'hFF, 32'hFF, 32'd0, 1'b1, "R1 R8 other opcode");
    // R2 logic ops
    drive(encR(7'd0, 3'd4), 32'hF0F0, 32'h0FF0, 32'hFF00, 1'b0, "R2 xor");
    drive(encR(7'd0, 3'd6), 32'hF000, 32'h000F, 32'hF00F, 1'b0, "R2 or");
    drive(encR(7'd0, 3'd7), 32'hF0F0, 32'h0FF0, 32'h00F0, 1'b0, "R2 and");
    // R2 random sweep against reference model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      ins = $urandom;
      ins[6:0] = (i % 2 == 0) ? 7'b0110011 : 7'b0010011;
      if (i % 3 != 0) begin
        ins[31:25] = (ins[31] ? 7'h20 : 7'h00);
      end
      driveRef(ins, $urandom, $urandom, "R2 random");
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule